// File: doc/BRIEF.md
# Prioritized Interrupt Flag Register

This block is the read-only interrupt cause register that an I/O adapter shows to its host. Four cause strobes feed it. Two come from the mailbox side: an outgoing mailbox slot became free, and an incoming mailbox was filled. Two come from the adapter side: a bus reset was seen, and a command finished. Each strobe is held in a pending latch until the ordering rules allow it into the visible flag register. A summary bit and a registered interrupt line then tell the host that something needs service.

Mailbox causes appear as soon as no adapter cause is on show. Adapter causes appear only when the flag register is empty and the data-in register is not holding a byte for the host. When both kinds wait together, the adapter cause goes first. The host reads the register and then pulses an interrupt-reset strobe. That strobe wipes what is visible but keeps what is still waiting. Hard reset, soft reset and power-on reset wipe everything.

Top module: `hostirq_flag_reg`

## Requirements
- R1: Read data carries the visible causes in bits 3..0: bit 0 incoming mailbox full, bit 1 outgoing mailbox free, bit 2 command complete, bit 3 bus reset seen. Bit 7 is the summary, set when any of bits 3..0 is set. Bits 6..4 always read 0.
- R2: A mailbox strobe sampled at clock edge E is latched at E. If no adapter cause is visible at E+1, it becomes visible at E+1. This also holds while other mailbox causes are already visible.
- R3: The irq output is the summary bit delayed by one clock.
- R4: While an adapter cause is visible, the mailbox bits of the register do not change. Mailbox causes held during that time become visible on the edge after the clearing edge.
- R5: An adapter cause becomes visible only on an edge where the register reads zero and data_full is low. If an adapter cause and a mailbox cause are both ready on the same edge, the adapter cause is shown and the mailbox cause keeps waiting.
- R6: A host_irq_rst pulse clears every visible cause on that edge. Nothing new is shown on that edge. Causes that are pending, or that arrive on that edge, are kept.
- R7: hard_rst or soft_rst on an edge, or rst_n low at any time, clears the visible causes, the pending causes and irq.
- R8: While mbx_avail_en is low, outgoing-mailbox strobes are ignored and any pending outgoing-mailbox cause is dropped.
- R9: No enabled cause is lost. Every strobe that the block accepts is shown later, unless a reset clears it first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| hard_rst | input | 1 | Hard reset strobe, synchronous |
| soft_rst | input | 1 | Soft reset strobe, synchronous |
| host_irq_rst | input | 1 | Host interrupt-reset strobe (control port bit 5 write) |
| data_full | input | 1 | Data-in register holds a byte for the host |
| mbx_avail_en | input | 1 | Enable for the outgoing-mailbox-free cause |
| ev_mbx_full | input | 1 | Incoming mailbox filled, one-cycle strobe |
| ev_mbx_avail | input | 1 | Outgoing mailbox slot freed, one-cycle strobe |
| ev_cmd_done | input | 1 | Command complete, one-cycle strobe |
| ev_scsi_rst | input | 1 | Bus reset detected, one-cycle strobe |
| rd_data | output | DATA_W | Flag register read value |
| irq | output | 1 | Interrupt line to the host |

## Verification
A strobe sampled at edge E reaches the pending latch at E and rd_data at E+1. The summary shows on irq one edge later, at E+2. A host clear empties rd_data at its own edge; held causes appear at the next edge, and irq falls one edge after the clear. The bench drives and samples at falling edges and counts rising edges between stimulus and check. Each check therefore lands in the exact cycle where the value is due. Where a cause must stay blocked, the bench also checks that nothing shows over several cycles.

// File: rtl/irqf_pkg.sv
package irqf_pkg;
  localparam int CAUSE_N       = 4;
  localparam int BIT_MBX_FULL  = 0;
  localparam int BIT_MBX_AVAIL = 1;
  localparam int BIT_CMD_DONE  = 2;
  localparam int BIT_SCSI_RST  = 3;

  typedef logic [CAUSE_N-1:0] cause_t;

  // adapter-class causes sit in bits 3..2
  function automatic logic adapter_active(cause_t v);
    return v[BIT_CMD_DONE] | v[BIT_SCSI_RST];
  endfunction

  function automatic logic mailbox_active(cause_t v);
    return v[BIT_MBX_FULL] | v[BIT_MBX_AVAIL];
  endfunction

  // which pending causes move into the visible register this edge
  function automatic cause_t select_take(cause_t pend, cause_t shown,
                                         logic dfull, logic clr_req);
    cause_t t;
    logic   adp_ok;
    logic   adp_go;
    logic   mbx_ok;
    adp_ok = (shown == '0) && !dfull && !clr_req;
    adp_go = adp_ok && adapter_active(pend);
    mbx_ok = !adapter_active(shown) && !clr_req && !adp_go;
    t = '0;
    t[BIT_CMD_DONE]  = pend[BIT_CMD_DONE]  & adp_ok;
    t[BIT_SCSI_RST]  = pend[BIT_SCSI_RST]  & adp_ok;
    t[BIT_MBX_FULL]  = pend[BIT_MBX_FULL]  & mbx_ok;
    t[BIT_MBX_AVAIL] = pend[BIT_MBX_AVAIL] & mbx_ok;
    return t;
  endfunction

  // read word: summary on top, causes at bottom, the rest zero
  function automatic logic [7:0] read_word(cause_t shown);
    logic [7:0] w;
    w = '0;
    w[CAUSE_N-1:0] = shown;
    w[7] = |shown;
    return w;
  endfunction
endpackage

// File: rtl/irqf_pending.sv
module irqf_pending #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_all,
  input  logic [N-1:0] set_req,
  input  logic [N-1:0] take,
  input  logic [N-1:0] keep_mask,
  output logic [N-1:0] pend
);
  for (genvar i = 0; i < N; i++) begin : g_latch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               pend[i] <= 1'b0;
      else if (clr_all)         pend[i] <= 1'b0;
      else if (set_req[i])      pend[i] <= 1'b1;
      else if (take[i] || !keep_mask[i]) pend[i] <= 1'b0;
    end

    // R9: an accepted strobe always lands in its latch
    assert_strobe_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (set_req[i] && !clr_all) |=> pend[i]);

    // R8: a cause whose enable is low is dropped
    assert_disabled_dropped_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!keep_mask[i] && !set_req[i]) |=> !pend[i]);
  end
endmodule

// File: rtl/irqf_gate.sv
module irqf_gate
  import irqf_pkg::*;
(
  input  cause_t pend,
  input  cause_t shown,
  input  logic   data_full,
  input  logic   host_clr,
  output cause_t take
);
  always_comb take = select_take(pend, shown, data_full, host_clr);
endmodule

// File: rtl/irqf_flags.sv
module irqf_flags
  import irqf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_all,
  input  logic              host_clr,
  input  logic              data_full,
  input  cause_t            take,
  output cause_t            shown,
  output logic              any_irq,
  output logic              irq,
  output logic [DATA_W-1:0] rd_data
);
  localparam int SUM_BIT = DATA_W - 1;

  logic adp_shown;
  assign adp_shown = adapter_active(shown);
  assign any_irq   = |shown;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        shown <= '0;
    else if (clr_all)  shown <= '0;
    else if (host_clr) shown <= '0;
    else               shown <= shown | take;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       irq <= 1'b0;
    else if (clr_all) irq <= 1'b0;
    else              irq <= any_irq;
  end

  always_comb begin
    rd_data = '0;
    rd_data[CAUSE_N-1:0] = shown;
    rd_data[SUM_BIT] = any_irq;
  end

  // R3: the line trails the summary by one edge
  assert_irq_trails_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_all |=> irq == $past(any_irq));

  // R4: mailbox bits frozen while an adapter cause is on show
  assert_mbx_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (adp_shown && !host_clr && !clr_all) |=>
      shown[BIT_MBX_AVAIL:BIT_MBX_FULL] == $past(shown[BIT_MBX_AVAIL:BIT_MBX_FULL]));

  // R5: adapter cause appears only from an empty register with data_full low
  assert_adapter_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|(shown[BIT_SCSI_RST:BIT_CMD_DONE] & ~$past(shown[BIT_SCSI_RST:BIT_CMD_DONE]))) |->
      ($past(shown) == '0 && !$past(data_full)));

  // R6: host clear leaves nothing visible
  assert_host_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    host_clr |=> shown == '0);

  // R7: synchronous resets drop flags and line
  assert_sync_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> (shown == '0 && !irq));
endmodule

// File: rtl/hostirq_flag_reg.sv
module hostirq_flag_reg
  import irqf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hard_rst,
  input  logic              soft_rst,
  input  logic              host_irq_rst,
  input  logic              data_full,
  input  logic              mbx_avail_en,
  input  logic              ev_mbx_full,
  input  logic              ev_mbx_avail,
  input  logic              ev_cmd_done,
  input  logic              ev_scsi_rst,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  logic   clr_all;
  cause_t set_req;
  cause_t keep_mask;
  cause_t pend;
  cause_t take;
  cause_t shown;
  logic   any_irq;

  assign clr_all = hard_rst | soft_rst;

  always_comb begin
    keep_mask = '1;
    keep_mask[BIT_MBX_AVAIL] = mbx_avail_en;
    set_req = '0;
    set_req[BIT_MBX_FULL]  = ev_mbx_full;
    set_req[BIT_MBX_AVAIL] = ev_mbx_avail & mbx_avail_en;
    set_req[BIT_CMD_DONE]  = ev_cmd_done;
    set_req[BIT_SCSI_RST]  = ev_scsi_rst;
  end

  irqf_pending #(.N(CAUSE_N)) u_pending (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_all   (clr_all),
    .set_req   (set_req),
    .take      (take),
    .keep_mask (keep_mask),
    .pend      (pend)
  );

  irqf_gate u_gate (
    .pend      (pend),
    .shown     (shown),
    .data_full (data_full),
    .host_clr  (host_irq_rst),
    .take      (take)
  );

  irqf_flags #(.DATA_W(DATA_W)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_all   (clr_all),
    .host_clr  (host_irq_rst),
    .data_full (data_full),
    .take      (take),
    .shown     (shown),
    .any_irq   (any_irq),
    .irq       (irq),
    .rd_data   (rd_data)
  );

  // R6: a host clear does not drop anything still waiting
  assert_pending_survives_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_irq_rst && !clr_all) |=> ((pend & $past(pend & keep_mask)) == $past(pend & keep_mask)));

  // R7: synchronous resets empty the pending latches
  assert_pending_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> pend == '0);

  // R1: summary bit agrees with the visible causes on every read
  assert_summary_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[DATA_W-1] == (shown != '0));
endmodule

// File: tb/hostirq_flag_reg_bench.sv
module hostirq_flag_reg_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, hard_rst = 1'b0, soft_rst = 1'b0, host_irq_rst = 1'b0;
  logic data_full = 1'b0, mbx_avail_en = 1'b1;
  logic ev_mbx_full = 1'b0, ev_mbx_avail = 1'b0, ev_cmd_done = 1'b0, ev_scsi_rst = 1'b0;
  logic [7:0] rd_data;
  logic irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // expected read words built from the R1 bit map
  localparam logic [7:0] SUM   = 8'h80;
  localparam logic [7:0] FULL  = 8'h01;
  localparam logic [7:0] AVAIL = 8'h02;
  localparam logic [7:0] CMD   = 8'h04;
  localparam logic [7:0] SRST  = 8'h08;

  hostirq_flag_reg u_hostirq_flag_reg (
    .clk(clk), .rst_n(rst_n), .hard_rst(hard_rst), .soft_rst(soft_rst),
    .host_irq_rst(host_irq_rst), .data_full(data_full), .mbx_avail_en(mbx_avail_en),
    .ev_mbx_full(ev_mbx_full), .ev_mbx_avail(ev_mbx_avail), .ev_cmd_done(ev_cmd_done),
    .ev_scsi_rst(ev_scsi_rst), .rd_data(rd_data), .irq(irq)
  );

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // ev bit order: {scsi_rst, cmd_done, mbx_avail, mbx_full}
  task automatic pulse(input logic [3:0] ev);
    {ev_scsi_rst, ev_cmd_done, ev_mbx_avail, ev_mbx_full} = ev;
    tick();
    {ev_scsi_rst, ev_cmd_done, ev_mbx_avail, ev_mbx_full} = 4'b0000;
  endtask

  task automatic hclr();
    host_irq_rst = 1'b1;
    tick();
    host_irq_rst = 1'b0;
  endtask

  task automatic t_reset();
    chk("R7", "rd after power-on", rd_data, 8'h00);
    chk("R7", "irq after power-on", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_mailbox();
    pulse(4'b0001);
    chk("R2", "rd one edge after strobe", rd_data, 8'h00);
    tick();
    chk("R1", "rd mailbox full", rd_data, SUM | FULL);
    chk("R3", "irq before delay", {7'b0, irq}, 8'h00);
    tick();
    chk("R3", "irq after delay", {7'b0, irq}, 8'h01);
    hclr();
    chk("R6", "rd after host clear", rd_data, 8'h00);
    chk("R3", "irq on clear edge", {7'b0, irq}, 8'h01);
    tick();
    chk("R3", "irq falls", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_adapter_first();
    pulse(4'b0101);
    tick();
    chk("R5", "adapter before mailbox", rd_data, SUM | CMD);
    repeat (3) tick();
    chk("R4", "mailbox held", rd_data, SUM | CMD);
    hclr();
    chk("R6", "cleared", rd_data, 8'h00);
    tick();
    chk("R4", "mailbox posted after clear", rd_data, SUM | FULL);
    hclr(); tick();
  endtask

  task automatic t_data_full();
    data_full = 1'b1;
    pulse(4'b1000);
    repeat (3) tick();
    chk("R5", "blocked by data_full", rd_data, 8'h00);
    data_full = 1'b0;
    tick();
    chk("R5", "shown after data_full drops", rd_data, SUM | SRST);
    hclr(); tick();
  endtask

  task automatic t_busy();
    pulse(4'b0010);
    tick();
    chk("R2", "mailbox free shown", rd_data, SUM | AVAIL);
    pulse(4'b0100);
    repeat (2) tick();
    chk("R5", "adapter blocked by summary", rd_data, SUM | AVAIL);
    pulse(4'b0001);
    tick();
    chk("R2", "second mailbox joins", rd_data, SUM | AVAIL | FULL);
    hclr();
    chk("R6", "clear shows nothing new", rd_data, 8'h00);
    tick();
    chk("R9", "held adapter shown", rd_data, SUM | CMD);
    hclr(); tick();
  endtask

  task automatic t_held();
    pulse(4'b1000);
    tick();
    chk("R5", "bus reset shown", rd_data, SUM | SRST);
    pulse(4'b0011);
    tick();
    chk("R4", "mailboxes held", rd_data, SUM | SRST);
    hclr();
    tick();
    chk("R9", "both mailboxes posted", rd_data, SUM | FULL | AVAIL);
    hclr(); tick();
    pulse(4'b0010);
    tick();
    host_irq_rst = 1'b1; ev_cmd_done = 1'b1;
    tick();
    host_irq_rst = 1'b0; ev_cmd_done = 1'b0;
    chk("R6", "clear with arrival", rd_data, 8'h00);
    tick();
    chk("R9", "arrival on clear edge kept", rd_data, SUM | CMD);
    hclr(); tick();
  endtask

  task automatic t_enable();
    mbx_avail_en = 1'b0;
    pulse(4'b0010);
    repeat (3) tick();
    chk("R8", "disabled strobe ignored", rd_data, 8'h00);
    mbx_avail_en = 1'b1;
    repeat (2) tick();
    chk("R8", "not latched while disabled", rd_data, 8'h00);
    pulse(4'b0100);
    tick();
    chk("R5", "command done shown", rd_data, SUM | CMD);
    pulse(4'b0010);
    mbx_avail_en = 1'b0;
    tick();
    mbx_avail_en = 1'b1;
    hclr();
    tick();
    chk("R8", "pending free slot dropped", rd_data, 8'h00);
    tick();
  endtask

  task automatic t_resets();
    pulse(4'b0001);
    tick(); tick();
    chk("R3", "irq up before hard reset", {7'b0, irq}, 8'h01);
    hard_rst = 1'b1; tick(); hard_rst = 1'b0;
    chk("R7", "rd after hard reset", rd_data, 8'h00);
    chk("R7", "irq after hard reset", {7'b0, irq}, 8'h00);
    pulse(4'b1000);
    tick();
    pulse(4'b0001);
    soft_rst = 1'b1; tick(); soft_rst = 1'b0;
    chk("R7", "irq after soft reset", {7'b0, irq}, 8'h00);
    repeat (2) tick();
    chk("R7", "pending gone after soft reset", rd_data, 8'h00);
    pulse(4'b0010);
    tick(); tick();
    rst_n = 1'b0;
    #1;
    chk("R7", "rd during power-on reset", rd_data, 8'h00);
    chk("R7", "irq during power-on reset", {7'b0, irq}, 8'h00);
    tick();
    rst_n = 1'b1;
    tick();
    chk("R7", "rd after power-on reset", rd_data, 8'h00);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_mailbox();
    t_adapter_first();
    t_data_full();
    t_busy();
    t_held();
    t_enable();
    t_resets();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual still running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule